// File: doc/BRIEF.md
# Calendar Alarm Comparator

This block watches the live calendar of a real-time clock and raises an alarm interrupt when the programmed alarm time is reached. It compares seconds, minutes, hours, day of week, day of month, month and a four-digit year against alarm values held in a small register file. Each of the six time and date alarm registers has its own enable bit. The year has an enable bit of its own in a control register. Only the enabled fields take part in the comparison.

Software writes the alarm registers through a plain write port. The comparison is sampled on the one-per-second tick from the counters. The interrupt flag is set on the first tick at which all enabled fields match, and then stays set until software clears it. A match that lasts across several ticks raises the flag only once. Power-on reset clears the enables and the flag. Manual reset clears only the flag and the match history. The alarm values are never reset. There is no data stream here, so every pin is a plain control or status pin with no valid/ready handshake.

Top module: `rtc_alarm_cmp`

## Requirements
- R1: After power-on reset (`por_n` low), `alarm_irq` is 0, and every field enable and the year enable are 0.
- R2: A write to address 0..5 (seconds, minutes, hours, weekday, day, month) stores `wr_data[7]` as the field enable and `wr_data[6:0]` as the BCD alarm value. Address 6 stores `wr_data[15:0]` as the BCD year. At address 7, `wr_data[0]` is the year enable and `wr_data[1]`=1 requests a clear of the flag. A write takes effect for comparisons from the next cycle.
- R3: A field whose enable is 0 has no effect on the match result.
- R4: The year takes part in the comparison only while the year enable is 1.
- R5: On a cycle with `sec_tick`=1, the flag is set if at least one enable is 1, every enabled field equals its zero-extended counter value, and the previous tick did not match.
- R6: While no enable is set, the flag is never set.
- R7: A match that persists over consecutive ticks sets the flag only once. The flag is not set again after a clear until a tick without a match has occurred.
- R8: Writing 1 to bit 1 at address 7 clears the flag. If a set condition occurs in the same cycle, the set wins.
- R9: `mrst` clears the flag and the match history. It leaves the enables and the alarm values unchanged, and it takes priority over a set.
- R10: The flag rises only on a cycle in which `sec_tick` is 1.
- R11: Power-on reset does not change the stored alarm values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| mrst | input | 1 | Synchronous manual reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| cur_sec | input | 7 | BCD seconds counter |
| cur_min | input | 7 | BCD minutes counter |
| cur_hour | input | 6 | BCD hours counter |
| cur_wday | input | 3 | Day-of-week counter |
| cur_day | input | 6 | BCD day-of-month counter |
| cur_mon | input | 5 | BCD month counter |
| cur_year | input | 16 | BCD four-digit year counter |
| alarm_irq | output | 1 | Alarm interrupt flag |

## Verification
The assertions assume that `sec_tick` is a clean one-cycle pulse that is sampled on the clock edge. They also assume that writes and manual reset are only asserted once power-on reset has been released. They do not assume that the alarm values are legal BCD, because range checking is out of scope.

The random stimulus drives the counters mostly to copies of the alarm values, so that full matches happen often. It also writes arbitrary 16-bit data, including values that are not BCD. Ticks, clears and manual resets are spread so that each one lands both alone and together with the others.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int NFIELD  = 6;
  localparam int VAL_W   = 7;
  localparam int YEAR_W  = 16;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 16;
  localparam int EN_BIT  = 7;
  localparam logic [ADDR_W-1:0] A_YEAR = 3'd6;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd7;
  localparam int CTRL_YEN = 0;
  localparam int CTRL_CLR = 1;
  typedef logic [VAL_W-1:0] fval_t;
endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              mrst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output fval_t             fld_val [NFIELD],
  output logic [NFIELD-1:0] fld_en,
  output logic [YEAR_W-1:0] year_val,
  output logic              year_en,
  output logic              clr_req
);
  // Alarm values carry no reset at all.
  for (genvar i = 0; i < NFIELD; i++) begin : g_fld
    always_ff @(posedge clk) begin
      if (wr_en && wr_addr == ADDR_W'(i)) fld_val[i] <= wr_data[VAL_W-1:0];
    end
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) fld_en[i] <= 1'b0;
      else if (wr_en && wr_addr == ADDR_W'(i)) fld_en[i] <= wr_data[EN_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_addr == A_YEAR) year_val <= wr_data[YEAR_W-1:0];
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) year_en <= 1'b0;
    else if (wr_en && wr_addr == A_CTRL) year_en <= wr_data[CTRL_YEN];
  end

  assign clr_req = wr_en && wr_addr == A_CTRL && wr_data[CTRL_CLR];

  AST_EN_KEPT_MRST: assert property (@(posedge clk) disable iff (!por_n)
    (mrst && !wr_en) |=> ($stable(fld_en) && $stable(year_en))); // R9
endmodule

// File: rtl/rtc_field_match.sv
module rtc_field_match #(
  parameter int W = 7
) (
  input  logic [W-1:0] alarm_val,
  input  logic [W-1:0] count_val,
  input  logic         enable,
  output logic         hit
);
  // A disabled field never blocks the match.
  assign hit = !enable || (alarm_val == count_val);

  always_comb begin
    if (!enable) AST_DISABLED_HIT: assert (hit); // R3
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              mrst,
  input  logic              sec_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [6:0]        cur_sec,
  input  logic [6:0]        cur_min,
  input  logic [5:0]        cur_hour,
  input  logic [2:0]        cur_wday,
  input  logic [5:0]        cur_day,
  input  logic [4:0]        cur_mon,
  input  logic [15:0]       cur_year,
  output logic              alarm_irq
);
  fval_t             fld_val [NFIELD];
  fval_t             fld_cur [NFIELD];
  logic [NFIELD-1:0] fld_en;
  logic [NFIELD-1:0] fld_hit;
  logic [YEAR_W-1:0] year_val;
  logic              year_en;
  logic              year_hit;
  logic              clr_req;
  logic              any_en;
  logic              all_match;
  logic              prev_match;

  rtc_alarm_regs u_regs (
    .clk(clk), .por_n(por_n), .mrst(mrst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .fld_val(fld_val), .fld_en(fld_en),
    .year_val(year_val), .year_en(year_en), .clr_req(clr_req)
  );

  assign fld_cur[0] = VAL_W'(cur_sec);
  assign fld_cur[1] = VAL_W'(cur_min);
  assign fld_cur[2] = VAL_W'(cur_hour);
  assign fld_cur[3] = VAL_W'(cur_wday);
  assign fld_cur[4] = VAL_W'(cur_day);
  assign fld_cur[5] = VAL_W'(cur_mon);

  for (genvar i = 0; i < NFIELD; i++) begin : g_cmp
    rtc_field_match #(.W(VAL_W)) u_match (
      .alarm_val(fld_val[i]), .count_val(fld_cur[i]),
      .enable(fld_en[i]), .hit(fld_hit[i])
    );
  end

  rtc_field_match #(.W(YEAR_W)) u_year (
    .alarm_val(year_val), .count_val(cur_year),
    .enable(year_en), .hit(year_hit)
  );

  assign any_en    = (|fld_en) || year_en;
  assign all_match = any_en && (&fld_hit) && year_hit;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      alarm_irq  <= 1'b0;
      prev_match <= 1'b0;
    end else if (mrst) begin
      alarm_irq  <= 1'b0;
      prev_match <= 1'b0;
    end else begin
      if (sec_tick) prev_match <= all_match;
      if (sec_tick && all_match && !prev_match) alarm_irq <= 1'b1;
      else if (clr_req) alarm_irq <= 1'b0;
    end
  end

  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!por_n)
    $rose(alarm_irq) |-> $past(sec_tick)); // R10
  AST_NO_EN_NO_IRQ: assert property (@(posedge clk) disable iff (!por_n)
    (!any_en) |=> !$rose(alarm_irq)); // R6
  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!por_n)
    (sec_tick && prev_match) |=> !$rose(alarm_irq)); // R7
  AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!por_n)
    (clr_req && !sec_tick) |=> !alarm_irq); // R8
  AST_MRST_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    mrst |=> !alarm_irq); // R9
endmodule

// File: tb/rtc_alarm_cmp_test.sv
module rtc_alarm_cmp_test;
  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic mrst = 1'b0, sec_tick = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [6:0] cur_sec = '0, cur_min = '0;
  logic [5:0] cur_hour = '0, cur_day = '0;
  logic [2:0] cur_wday = '0;
  logic [4:0] cur_mon = '0;
  logic [15:0] cur_year = '0;
  logic alarm_irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [6:0] m_val [6];
  bit m_en [6];
  logic [15:0] m_year;
  bit m_yen, m_flag, m_prev;

  always #4 clk = ~clk;

  rtc_alarm_cmp uut (
    .clk(clk), .por_n(por_n), .mrst(mrst), .sec_tick(sec_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_wday(cur_wday), .cur_day(cur_day), .cur_mon(cur_mon),
    .cur_year(cur_year), .alarm_irq(alarm_irq)
  );

  function automatic logic [6:0] cur_of(int i);
    case (i)
      0: return cur_sec;
      1: return cur_min;
      2: return 7'(cur_hour);
      3: return 7'(cur_wday);
      4: return 7'(cur_day);
      default: return 7'(cur_mon);
    endcase
  endfunction

  function automatic bit model_match();
    bit any = m_yen;
    bit ok = !m_yen || (m_year == cur_year);
    for (int i = 0; i < 6; i++) begin
      any = any | m_en[i];
      if (m_en[i] && m_val[i] != cur_of(i)) ok = 0;
    end
    return any && ok;
  endfunction

  task automatic check(input bit act, input bit exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: alarm_irq=%0b expected %0b", tag, act, exp);
    end
  endtask

  // Drive one cycle, update model at the edge, check after it.
  task automatic step(input bit tk, input bit we, input logic [2:0] a,
                      input logic [15:0] d, input bit mr, input string tag);
    bit mt;
    sec_tick = tk; wr_en = we; wr_addr = a; wr_data = d; mrst = mr;
    @(posedge clk);
    mt = model_match();
    if (mr) begin
      m_flag = 0; m_prev = 0;
    end else begin
      if (tk && mt && !m_prev) m_flag = 1;
      else if (we && a == 3'd7 && d[1]) m_flag = 0;
      if (tk) m_prev = mt;
    end
    if (we) begin
      if (a < 3'd6) begin m_val[a] = d[6:0]; m_en[a] = d[7]; end
      else if (a == 3'd6) m_year = d;
      else m_yen = d[0];
    end
    @(negedge clk);
    check(alarm_irq, m_flag, tag);
    sec_tick = 0; wr_en = 0; mrst = 0;
  endtask

  task automatic do_por();
    @(negedge clk); por_n = 0;
    repeat (2) @(negedge clk);
    por_n = 1;
    for (int i = 0; i < 6; i++) m_en[i] = 0;
    m_yen = 0; m_flag = 0; m_prev = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd12345));
    for (int i = 0; i < 6; i++) begin m_val[i] = '0; m_en[i] = 0; end
    m_year = '0;
    do_por();
    check(alarm_irq, 1'b0, "R1 reset state");
    cur_sec = 7'h30; cur_min = 7'h15; cur_hour = 6'h12;
    cur_wday = 3'd3; cur_day = 6'h21; cur_mon = 5'h06; cur_year = 16'h2024;
    // R2: load all values disabled
    step(0, 1, 3'd0, 16'h0030, 0, "R2");
    step(0, 1, 3'd1, 16'h0015, 0, "R2");
    step(0, 1, 3'd2, 16'h0012, 0, "R2");
    step(0, 1, 3'd3, 16'h0003, 0, "R2");
    step(0, 1, 3'd4, 16'h0021, 0, "R2");
    step(0, 1, 3'd5, 16'h0006, 0, "R2");
    step(0, 1, 3'd6, 16'h2024, 0, "R2");
    step(1, 0, 3'd0, 16'h0, 0, "R6");
    check(alarm_irq, 1'b0, "R6 no enable");
    step(0, 1, 3'd0, 16'h00B0, 0, "R2");
    step(1, 0, 3'd0, 16'h0, 0, "R5");
    check(alarm_irq, 1'b1, "R5 seconds match");
    step(1, 0, 3'd0, 16'h0, 0, "R7");
    step(0, 1, 3'd7, 16'h0002, 0, "R8");
    check(alarm_irq, 1'b0, "R8 clear");
    step(1, 0, 3'd0, 16'h0, 0, "R7");
    check(alarm_irq, 1'b0, "R7 no re-raise");
    cur_min = 7'h44;  // minutes disabled: ignored
    cur_sec = 7'h31;
    step(1, 0, 3'd0, 16'h0, 0, "R3");
    cur_sec = 7'h30;
    step(1, 0, 3'd0, 16'h0, 0, "R3");
    check(alarm_irq, 1'b1, "R3 disabled minutes ignored");
    cur_min = 7'h15;
    step(0, 1, 3'd7, 16'h0002, 0, "R8");
    cur_year = 16'h2025;
    step(0, 1, 3'd7, 16'h0001, 0, "R4");
    cur_sec = 7'h31; step(1, 0, 3'd0, 16'h0, 0, "R4");
    cur_sec = 7'h30; step(1, 0, 3'd0, 16'h0, 0, "R4");
    check(alarm_irq, 1'b0, "R4 year mismatch blocks");
    step(0, 1, 3'd7, 16'h0000, 0, "R4");
    cur_sec = 7'h31; step(1, 0, 3'd0, 16'h0, 0, "R4");
    cur_sec = 7'h30;
    step(1, 1, 3'd7, 16'h0002, 0, "R8");
    check(alarm_irq, 1'b1, "R8 set wins over clear");
    step(0, 0, 3'd0, 16'h0, 1, "R9");
    check(alarm_irq, 1'b0, "R9 manual reset clears flag");
    step(1, 0, 3'd0, 16'h0, 0, "R9");
    check(alarm_irq, 1'b1, "R9 enables kept after manual reset");
    do_por();
    check(alarm_irq, 1'b0, "R1 power-on clears flag");
    step(1, 0, 3'd0, 16'h0, 0, "R1");
    check(alarm_irq, 1'b0, "R1 enables cleared");
    cur_year = 16'h2024; cur_sec = 7'h59;
    step(0, 1, 3'd7, 16'h0001, 0, "R11");
    step(1, 0, 3'd0, 16'h0, 0, "R11");
    check(alarm_irq, 1'b1, "R11 year value kept over power-on");
    cur_year = 16'h1999;
    step(0, 1, 3'd7, 16'h0003, 0, "R11");
    step(1, 0, 3'd0, 16'h0, 0, "R11");
    check(alarm_irq, 1'b0, "R11 year compared to kept value");
    // Random phase
    for (int n = 0; n < 4000; n++) begin
      bit tk, we, mr;
      logic [2:0] a;
      logic [15:0] d;
      tk = ($urandom % 3) != 0;
      we = ($urandom % 4) == 0;
      mr = ($urandom % 97) == 0;
      a = 3'($urandom);
      d = 16'($urandom);
      if (a < 3'd6 && ($urandom % 2)) d = {8'h0, d[7], m_val[a]};
      if (($urandom % 4) != 0) begin
        cur_sec = m_val[0]; cur_min = m_val[1]; cur_hour = m_val[2][5:0];
        cur_wday = m_val[3][2:0]; cur_day = m_val[4][5:0];
        cur_mon = m_val[5][4:0]; cur_year = m_year;
      end else begin
        cur_sec = 7'($urandom); cur_year = ($urandom % 2) ? m_year : 16'($urandom);
      end
      step(tk, we, a, d, mr, "R5 random");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule